// File: doc/BRIEF.md
# LED Matrix Running Dot Scanner

This block drives an 8x8 LED matrix so that a single lit dot sweeps across it. The dot moves one column to the right on every step. When it leaves the rightmost column, it returns to the leftmost column and drops one row. After the bottom-right position, the dot goes back to the top-left corner.

Steps come from a free-running prescaler on the fast system clock. The prescaler produces a one-cycle step enable, so the whole block runs in a single clock domain. It never uses a divided signal as a clock.

The column bus is active high and the row bus is active low. The block can connect directly to a matrix whose anodes are on the columns and whose cathodes are on the rows. The prescaler width is a parameter. The default of 24 bits gives a visible step rate at 50 MHz, and a small value allows a full sweep in a short simulation.

Top module: `running_dot_scan`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block returns to its start state. The start state is `col_on_o` = 8'h80 (only bit 7 high), `row_n_o` = 8'h7F (only bit 7 low), and a prescaler count of zero.
- R2: After reset is released, a step happens once every 2^PRESCALE_W clock cycles. The first change of the outputs happens at the 2^PRESCALE_W-th rising edge after the last edge with reset high.
- R3: On each step, `col_on_o` rotates right by one position: bit 0 moves into bit 7 and every other bit moves down by one.
- R4: `row_n_o` rotates right by one position only on a step where `col_on_o` equals 8'h01. On every other step, and between steps, it keeps its value.
- R5: At every clock cycle outside reset, exactly one bit of `col_on_o` is high and exactly one bit of `row_n_o` is low.
- R6: After 64 steps, both buses are back to their start values (8'h80 and 8'h7F).
- R7: Between two steps, neither output bus changes.
- R8: A reset applied in the middle of a sweep also restarts the prescaler. The next step then comes a full 2^PRESCALE_W cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| col_on_o | output | 8 | Column drive, one-hot, active high; bit 7 is the leftmost column |
| row_n_o | output | 8 | Row drive, one-cold, active low; bit 7 is the top row |

## Verification
The bench sets a 3-bit prescaler and follows all 64 steps, checking the outputs on every cycle. This catches a design that steps one cycle early or late, or that lets the outputs move between steps.

At each column wrap, the bench checks that the row moves on exactly the step where the column goes from 8'h01 back to 8'h80. A design that decodes the wrap from the new column value instead of the old one would move the row one step late.

The bench also checks the final return to the top-left corner. A rotation in the wrong direction would make the dot run right to left instead.

A reset applied partway through a period exposes a prescaler that is not cleared. Such a design would take its next step too early.

// File: rtl/dot_scan_pkg.sv
package dot_scan_pkg;
    localparam int unsigned MATRIX_N = 8;
    localparam logic [MATRIX_N-1:0] COL_START = {1'b1, {(MATRIX_N-1){1'b0}}};
    localparam logic [MATRIX_N-1:0] ROW_START = {1'b0, {(MATRIX_N-1){1'b1}}};

    typedef struct packed {
        logic [MATRIX_N-1:0] pat;
    } ring_state_t;

    function automatic logic [MATRIX_N-1:0] rot_right(input logic [MATRIX_N-1:0] v);
        return {v[0], v[MATRIX_N-1:1]};
    endfunction
endpackage

// File: rtl/dot_prescaler.sv
module dot_prescaler #(
    parameter int unsigned PRESCALE_W = 24
) (
    input  logic clk,
    input  logic rst,
    output logic step_o
);
    typedef struct packed {
        logic [PRESCALE_W-1:0] cnt;
    } pre_state_t;

    localparam logic [PRESCALE_W-1:0] TERMINAL = {PRESCALE_W{1'b1}};

    pre_state_t state_d, state_q;

    always_comb begin
        state_d.cnt = state_q.cnt + 1'b1;
        step_o      = (state_q.cnt == TERMINAL);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    // R2: without a step, the counter moves up by exactly one
    assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
        !step_o |=> state_q.cnt == $past(state_q.cnt) + 1'b1);
    // R2: a step is always followed by a count of zero
    assert_step_wraps_R2: assert property (@(posedge clk) disable iff (rst)
        step_o |=> state_q.cnt == '0);
    // R8: reset clears the prescaler
    assert_pre_reset_R8: assert property (@(posedge clk)
        rst |=> state_q.cnt == '0);
endmodule

// File: rtl/dot_col_ring.sv
module dot_col_ring
    import dot_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                step_i,
    output logic [MATRIX_N-1:0] col_o,
    output logic                wrap_o
);
    ring_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step_i) state_d.pat = rot_right(state_q.pat);
        wrap_o = step_i & state_q.pat[0];
        col_o  = state_q.pat;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q.pat <= COL_START;
        else     state_q     <= state_d;
    end

    // R3: each step moves the dot one column to the right
    assert_col_rotate_R3: assert property (@(posedge clk) disable iff (rst)
        step_i |=> state_q.pat == {$past(state_q.pat[0]), $past(state_q.pat[MATRIX_N-1:1])});
    // R7: no step means no column change
    assert_col_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(state_q.pat));
    // R5: exactly one column is lit
    assert_col_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot(state_q.pat));
endmodule

// File: rtl/dot_row_ring.sv
module dot_row_ring
    import dot_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                adv_i,
    output logic [MATRIX_N-1:0] row_n_o
);
    ring_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (adv_i) state_d.pat = rot_right(state_q.pat);
        row_n_o = state_q.pat;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q.pat <= ROW_START;
        else     state_q     <= state_d;
    end

    // R4: an advance moves the active row down by one
    assert_row_rotate_R4: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> state_q.pat == {$past(state_q.pat[0]), $past(state_q.pat[MATRIX_N-1:1])});
    // R4: without an advance the row holds
    assert_row_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(state_q.pat));
    // R5: exactly one row is driven low
    assert_row_onecold_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot(~state_q.pat));
endmodule

// File: rtl/running_dot_scan.sv
module running_dot_scan
    import dot_scan_pkg::*;
#(
    parameter int unsigned PRESCALE_W = 24
) (
    input  logic       clk,
    input  logic       rst,
    output logic [7:0] col_on_o,
    output logic [7:0] row_n_o
);
    logic                step;
    logic                wrap;
    logic [MATRIX_N-1:0] col;
    logic [MATRIX_N-1:0] row_n;

    dot_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .step_o (step)
    );

    dot_col_ring u_col (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .col_o  (col),
        .wrap_o (wrap)
    );

    dot_row_ring u_row (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (wrap),
        .row_n_o (row_n)
    );

    assign col_on_o = col;
    assign row_n_o  = row_n;

    // R1: reset yields the top-left dot
    assert_reset_pattern_R1: assert property (@(posedge clk)
        rst |=> (col_on_o == 8'h80) && (row_n_o == 8'h7F));
    // R4: the row changes only when the column left bit 0
    assert_row_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (row_n_o != $past(row_n_o)) |-> ($past(col_on_o) == 8'h01) && (col_on_o == 8'h80));
endmodule

// File: tb/sim_running_dot_scan.sv
module sim_running_dot_scan;
    localparam int CLK_PERIOD = 10;
    localparam int PW         = 3;
    localparam int PERIOD     = 1 << PW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] col_on_o;
    logic [7:0] row_n_o;
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    running_dot_scan #(.PRESCALE_W(PW)) u0 (
        .clk      (clk),
        .rst      (rst),
        .col_on_o (col_on_o),
        .row_n_o  (row_n_o)
    );

    function automatic logic [7:0] exp_col(input int s);
        return 8'h80 >> (s % 8);
    endfunction

    function automatic logic [7:0] exp_row(input int s);
        return ~(8'h80 >> ((s / 8) % 8));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_onehot;
        n_checks++;
        if (!$onehot(col_on_o) || !$onehot(~row_n_o)) begin
            n_fail++;
            $display("FAIL R5: actual col %h row %h expected one-hot/one-cold", col_on_o, row_n_o);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 col", col_on_o, 8'h80);
        chk("R1 row", row_n_o, 8'h7F);
        rst = 1'b0;
        for (int s = 1; s <= 64; s++) begin
            for (int c = 1; c < PERIOD; c++) begin
                @(negedge clk);
                chk("R7 col hold", col_on_o, exp_col(s - 1));
                chk("R7 row hold", row_n_o, exp_row(s - 1));
                chk_onehot();
            end
            @(negedge clk);
            chk((s == 1) ? "R2 first step" : "R3 col step", col_on_o, exp_col(s));
            chk("R4 row step", row_n_o, exp_row(s));
            chk_onehot();
            if (s == 64) begin
                chk("R6 col wrap", col_on_o, 8'h80);
                chk("R6 row wrap", row_n_o, 8'h7F);
            end
        end
        // mid-period reset: advance two steps plus a few cycles
        repeat (2 * PERIOD + 3) @(negedge clk);
        chk("R3 pre-reset col", col_on_o, 8'h20);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 col", col_on_o, 8'h80);
        chk("R8 row", row_n_o, 8'h7F);
        rst = 1'b0;
        for (int c = 1; c < PERIOD; c++) begin
            @(negedge clk);
            chk("R8 hold after reset", col_on_o, 8'h80);
        end
        @(negedge clk);
        chk("R8 full period step", col_on_o, 8'h40);
        chk("R8 row after step", row_n_o, 8'h7F);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule